// File: doc/BRIEF.md
# Stack Register-List Save/Restore Sequencer

This block carries out a "move multiple" operation for a 32-bit processor core. Given a start pulse, a direction, an 8-bit register-list selection and the current stack pointer, it moves the selected registers between the register file and the stack. Each memory transaction carries one 32-bit word. When every transfer has finished, it writes the final stack pointer once and pulses done. The instruction decoder upstream sets the direction from the opcode byte: 0xCE is a restore (pop) and 0xCF is a save (push).

The registers do not follow index order. Four single-register selections cover D2, D3, A2 and A3. One selection bit covers a group of seven registers (D0, D1, A0, A1, MDR, LIR, LAR), and this group also takes one empty word slot on the stack. A save walks downward from the stack pointer and decrements it before each store. A restore walks upward in the exact reverse order, so a save followed by a restore of the same selection leaves the stack pointer and the registers where they started.

The block drives a combinational register-file read port, a register-file write port, a stack-pointer write strobe and a single-outstanding word memory interface. A memory request completes on its valid/ready handshake. A read also waits for a response, which arrives no earlier than the cycle after the handshake.

Top module: `regmove_seq`

## Requirements
- R1: Register indices on the register-file ports are D0..D3 = 0..3, A0..A3 = 4..7, MDR = 8, LIR = 9 and LAR = 10. Selection bits are mask[7]=D2, mask[6]=D3, mask[5]=A2, mask[4]=A3 and mask[3]=the seven-register group. mask[2:0] has no effect.
- R2: On a save, registers are stored in the order D2, D3, A2, A3, D0, D1, A0, A1, MDR, LIR, LAR, skipping unselected ones. The k-th store (k from 0) goes to address sp_in − 4·(k+1).
- R3: On a save that selects the group, one further word below LAR is left unwritten. The final stack pointer is sp_in − 4·(popcount(mask[7:4]) + 8·mask[3]).
- R4: On a restore that selects the group, the word at sp_in is skipped. LAR, LIR, MDR, A1, A0, D1 and D0 are then loaded from ascending addresses, followed by A3, A2, D3 and D2. Each load reads the next word up. The final stack pointer is sp_in + 4·(popcount(mask[7:4]) + 8·mask[3]).
- R5: On a restore, a register-file write happens only in the cycle a read response is accepted. It carries that response's data and the index of the register the load belongs to. Unselected registers are not written.
- R6: sp_we is asserted exactly once per operation, in the same cycle as done, after every transfer has finished, and with no memory request or register write in that cycle.
- R7: If mask[7:3] is zero, done is asserted in the cycle after start with no memory request, and sp_wr_data equals sp_in.
- R8: done lasts one cycle. A start seen while busy is ignored and does not change the operation in progress.
- R9: While mem_req_valid is high and mem_req_ready is low, the request stays valid with the same address and direction.
- R10: A save makes no register-file writes. A restore issues no memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| push | input | 1 | 1 = save to stack, 0 = restore from stack |
| mask | input | 8 | Register-list selection |
| sp_in | input | ADDR_W | Stack pointer at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_rd_idx | output | IDX_W | Register-file read index |
| rf_rd_data | input | DATA_W | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write strobe |
| rf_wr_idx | output | IDX_W | Register-file write index |
| rf_wr_data | output | DATA_W | Register-file write data |
| sp_we | output | 1 | Stack-pointer write strobe |
| sp_wr_data | output | ADDR_W | Final stack pointer |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | ADDR_W | Word byte address |
| mem_req_wdata | output | DATA_W | Store data |
| mem_rsp_valid | input | 1 | Load response valid |
| mem_rsp_rdata | input | DATA_W | Load response data |

## Verification
The bench uses the default widths: 32-bit data and address and a 4-bit register index. This makes the full eleven-register file and word-aligned byte addressing with a 4-byte step visible at the ports. A small memory window around a mid-range stack pointer holds both the save area and the restore area, so the untouched group gap word and the neighbours outside the touched range can be compared word by word. Random memory ready and response latency exercise request holding and the gating of register writes by responses.

// File: rtl/regmove_seq.sv
module regmove_seq #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              push,
  input  logic [7:0]        mask,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_wr_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);

  localparam int SLOTS = 12;
  localparam int GAP   = SLOTS - 1;
  localparam int POS_W = $clog2(SLOTS);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_WAIT, S_FIN} st_t;

  st_t               st;
  logic              dir_q;
  logic [SLOTS-1:0]  rem, rem_nxt, sel_in;
  logic [ADDR_W-1:0] cur, cur_nxt;
  logic [POS_W-1:0]  pos;
  logic [IDX_W-1:0]  reg_idx;
  logic              is_gap, advance;

  // slot 0..3: D2 D3 A2 A3; slot 4..10: group; slot 11: gap word
  assign sel_in = {{8{mask[3]}}, mask[4], mask[5], mask[6], mask[7]};

  always_comb begin
    pos = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (dir_q) begin
        if (rem[SLOTS-1-i]) pos = POS_W'(SLOTS - 1 - i);
      end else if (rem[i]) begin
        pos = POS_W'(i);
      end
    end
  end

  always_comb begin
    case (pos)
      4'd0:    reg_idx = IDX_W'(2);
      4'd1:    reg_idx = IDX_W'(3);
      4'd2:    reg_idx = IDX_W'(6);
      4'd3:    reg_idx = IDX_W'(7);
      4'd4:    reg_idx = IDX_W'(0);
      4'd5:    reg_idx = IDX_W'(1);
      4'd6:    reg_idx = IDX_W'(4);
      4'd7:    reg_idx = IDX_W'(5);
      4'd8:    reg_idx = IDX_W'(8);
      4'd9:    reg_idx = IDX_W'(9);
      default: reg_idx = IDX_W'(10);
    endcase
  end

  assign is_gap  = (pos == POS_W'(GAP));
  assign rem_nxt = rem & ~(SLOTS'(1) << pos);
  assign cur_nxt = dir_q ? cur - STEP : cur + STEP;

  assign busy          = (st != S_IDLE);
  assign done          = (st == S_FIN);
  assign sp_we         = done;
  assign sp_wr_data    = cur;
  assign rf_rd_idx     = reg_idx;
  assign mem_req_valid = (st == S_STEP) && !is_gap;
  assign mem_req_write = dir_q;
  assign mem_req_addr  = dir_q ? cur - STEP : cur;
  assign mem_req_wdata = rf_rd_data;
  assign rf_we         = (st == S_WAIT) && mem_rsp_valid;
  assign rf_wr_idx     = reg_idx;
  assign rf_wr_data    = mem_rsp_rdata;
  assign advance       = ((st == S_STEP) && (is_gap || (dir_q && mem_req_ready))) || rf_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      dir_q <= 1'b0;
      rem   <= '0;
      cur   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          dir_q <= push;
          rem   <= sel_in;
          cur   <= sp_in;
          st    <= (|sel_in) ? S_STEP : S_FIN;
        end
        S_STEP, S_WAIT: begin
          if (advance) begin
            rem <= rem_nxt;
            cur <= cur_nxt;
            st  <= (|rem_nxt) ? S_STEP : S_FIN;
          end else if (st == S_STEP && mem_req_valid && mem_req_ready) begin
            st <= S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R7
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mask[7:3] == 5'd0) |=> (done && !mem_req_valid && sp_wr_data == $past(sp_in)));

  // R2
  push_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |=>
      (!mem_req_valid || mem_req_addr == $past(mem_req_addr) - STEP));

  // R6
  sp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> (!mem_req_valid && !rf_we));

  // R10
  push_no_rfw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |=> !rf_we);

endmodule

// File: tb/regmove_seq_tb.sv
module regmove_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, push = 1'b0;
  logic [7:0]  mask = 8'h00;
  logic [31:0] sp_in = 32'h0;
  logic        busy, done, rf_we, sp_we, mem_req_valid, mem_req_write;
  logic [3:0]  rf_rd_idx, rf_wr_idx;
  logic [31:0] rf_rd_data, rf_wr_data, sp_wr_data, mem_req_addr, mem_req_wdata;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = 32'h0;

  logic [31:0] mem [0:1023];
  logic [31:0] exp_mem [0:1023];
  logic [31:0] regs [0:15];
  logic [31:0] exp_regs [0:15];

  int n_cmp = 0, n_bad = 0;
  int done_cnt = 0, spw_cnt = 0, rfw_cnt = 0, mw_cnt = 0, mreq_cnt = 0;
  bit rd_pend = 0;
  int rd_wait = 0;
  logic [9:0] rd_idx = '0;
  bit finished = 0;

  always #10 clk = ~clk;

  regmove_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .push(push), .mask(mask), .sp_in(sp_in),
    .busy(busy), .done(done), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .sp_we(sp_we), .sp_wr_data(sp_wr_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata)
  );

  assign rf_rd_data = regs[rf_rd_idx];

  always @(posedge clk) begin
    mem_req_ready <= ($urandom_range(0, 3) != 0);
    mem_rsp_valid <= 1'b0;
    if (rst_n) begin
      if (rd_pend) begin
        if (rd_wait == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= mem[rd_idx];
          rd_pend <= 0;
        end else rd_wait <= rd_wait - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        mreq_cnt++;
        if (mem_req_write) begin
          mem[mem_req_addr[11:2]] <= mem_req_wdata;
          mw_cnt++;
        end else begin
          rd_pend <= 1;
          rd_wait <= $urandom_range(0, 2);
          rd_idx  <= mem_req_addr[11:2];
        end
      end
      if (rf_we) begin
        regs[rf_wr_idx] <= rf_wr_data;
        rfw_cnt++;
      end
      if (done) done_cnt++;
      if (sp_we) spw_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ordreg(input int p);
    case (p)
      0: return 2;  1: return 3;  2: return 6;  3: return 7;
      4: return 0;  5: return 1;  6: return 4;  7: return 5;
      8: return 8;  9: return 9;  default: return 10;
    endcase
  endfunction

  function automatic bit selp(input logic [7:0] m, input int p);
    return (p < 4) ? m[7-p] : m[3];
  endfunction

  function automatic int nsel(input logic [7:0] m);
    return int'(m[7]) + int'(m[6]) + int'(m[5]) + int'(m[4]) + 8 * int'(m[3]);
  endfunction

  task automatic launch(input bit p, input logic [7:0] m, input logic [31:0] sp);
    @(negedge clk);
    done_cnt = 0; spw_cnt = 0; rfw_cnt = 0; mw_cnt = 0; mreq_cnt = 0;
    start = 1; push = p; mask = m; sp_in = sp;
    @(negedge clk);
    start = 0; mask = 8'($urandom); sp_in = $urandom; push = $urandom_range(0, 1);
  endtask

  task automatic wait_done(output logic [31:0] spv, output int cyc);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    spv = sp_wr_data;
    chk(done == 1'b1 && sp_we == 1'b1, "R6 completion seen", {30'd0, sp_we, done}, 32'd3);
    @(negedge clk);
    chk(done == 1'b0 && done_cnt == 1, "R8 done single pulse", done_cnt, 32'd1);
    chk(spw_cnt == 1, "R6 one sp write", spw_cnt, 32'd1);
  endtask

  task automatic do_push(input logic [7:0] m, input logic [31:0] sp);
    logic [31:0] a, spv;
    int n, cyc;
    for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
    a = sp; n = 0;
    for (int p = 0; p < 11; p++) if (selp(m, p)) begin
      a -= 4; exp_mem[a[11:2]] = regs[ordreg(p)]; n++;
    end
    if (m[3]) a -= 4;
    launch(1, m, sp);
    wait_done(spv, cyc);
    chk(spv == a, "R3 push final sp", spv, a);
    chk(mw_cnt == n, "R2 store count", mw_cnt, n);
    chk(rfw_cnt == 0, "R10 no reg write on push", rfw_cnt, 0);
    for (int i = -16; i < 4; i++) begin
      logic [31:0] wa;
      wa = sp + 32'(i * 4);
      chk(mem[wa[11:2]] == exp_mem[wa[11:2]], "R2 R3 stack word", mem[wa[11:2]], exp_mem[wa[11:2]]);
    end
  endtask

  task automatic do_pop(input logic [7:0] m, input logic [31:0] sp);
    logic [31:0] a, spv;
    int n, cyc;
    for (int i = 0; i < 16; i++) exp_regs[i] = regs[i];
    a = sp; n = 0;
    if (m[3]) a += 4;
    for (int p = 10; p >= 0; p--) if (selp(m, p)) begin
      exp_regs[ordreg(p)] = mem[a[11:2]]; a += 4; n++;
    end
    launch(0, m, sp);
    wait_done(spv, cyc);
    chk(spv == a, "R4 pop final sp", spv, a);
    chk(rfw_cnt == n, "R5 reg write count", rfw_cnt, n);
    chk(mw_cnt == 0, "R10 no mem write on pop", mw_cnt, 0);
    for (int i = 0; i < 11; i++)
      chk(regs[i] == exp_regs[i], "R4 R5 restored reg", regs[i], exp_regs[i]);
  endtask

  initial begin
    logic [31:0] spv;
    int cyc;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA5000000 | 32'(i);
    for (int i = 0; i < 16; i++) regs[i] = 32'h11110000 + 32'(i * 32'h101);
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(!busy && !done && !mem_req_valid && !rf_we && !sp_we, "R6 reset state",
        {27'd0, busy, done, mem_req_valid, rf_we, sp_we}, 32'd0);

    // R7 zero selection, and R1 low bits ignored
    launch(1, 8'h00, 32'h800);
    chk(done == 1'b1, "R7 done next cycle", done, 1);
    wait_done(spv, cyc);
    chk(spv == 32'h800 && mreq_cnt == 0, "R7 zero mask sp", spv, 32'h800);
    launch(0, 8'h07, 32'h804);
    chk(done == 1'b1, "R1 low bits ignored latency", done, 1);
    wait_done(spv, cyc);
    chk(spv == 32'h804 && mreq_cnt == 0 && rfw_cnt == 0, "R1 low bits ignored", spv, 32'h804);

    // directed save/restore, R1 R2 R3 R4
    do_push(8'h80, 32'h800);
    do_push(8'h08, 32'h840);
    do_push(8'hFF, 32'h880);
    for (int i = 0; i < 11; i++) regs[i] = 32'hC0DE0000 | 32'(i);
    do_pop(8'hFF, 32'h880 - 32'd48);
    chk(regs[2] == 32'h11110202 && regs[10] == 32'h11110A0A, "R4 round trip", regs[10], 32'h11110A0A);
    do_pop(8'h10, 32'h900);

    // R8 start while busy ignored
    for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
    launch(1, 8'hF8, 32'h9C0);
    @(negedge clk);
    start = 1; push = 0; mask = 8'h90; sp_in = 32'h100;
    @(negedge clk);
    start = 0;
    wait_done(spv, cyc);
    chk(spv == 32'h9C0 - 32'd48, "R8 start while busy ignored", spv, 32'h9C0 - 32'd48);
    chk(mw_cnt == 11 && rfw_cnt == 0, "R8 busy op unchanged", mw_cnt, 11);

    // random mix
    for (int t = 0; t < 60; t++) begin
      logic [7:0] m;
      logic [31:0] sp;
      m = 8'($urandom);
      sp = 32'h700 + 32'($urandom_range(0, 64)) * 4;
      for (int i = 0; i < 11; i++) regs[i] = $urandom;
      if ($urandom_range(0, 1) != 0) do_push(m, sp);
      else do_pop(m, sp);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(150000 * 20);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule